// File: doc/BRIEF.md
# Multi-Domain Clock Ratio Enable Generator

This block turns one fast source clock into five clock-enable streams: CPU, system bus, peripheral, memory and display. Each stream is a one-cycle pulse that repeats at a rate picked by a 4-bit ratio code. The codes map onto a fixed, non-linear set of ratios, and that set includes odd values. A sixth output, the auxiliary enable, runs either at the full source rate or at half of it. A single configuration strobe captures all five codes at once, together with the rate-select bit, the run bit and a settle count.

All dividers advance against a shared 96-cycle frame. 96 is the least common multiple of every ratio in the set, so each divider sits at its own pulse boundary when the frame wraps. A new code set that arrives while the block is running waits for that wrap, then all dividers restart together. This means no stream ever produces a short or doubled pulse.

When the block is started from stop, the settle count holds every output low for a programmed number of cycles. This models the wait for the source clock to become stable. After the wait, the block raises its ready flag and emits the first pulse on every stream in the same cycle.

Top module: `clk_ratio_gen`

## Requirements
- R1: While reset is held, all domain enables, the auxiliary enable and the ready flag are 0.
- R2: Ratio codes 0 through 9 give a pulse every 1, 2, 3, 4, 6, 8, 12, 16, 24 and 32 source cycles, in that order. Domain d reads its code from bits [4d+3:4d] of the code bus: d=0 CPU, 1 bus, 2 peripheral, 3 memory, 4 display.
- R3: Codes 10 through 15 behave as divide-by-one, giving a pulse every cycle.
- R4: In the first cycle with ready high, every domain pulses. After that, domain d pulses exactly when the number of cycles since that first cycle is a multiple of its ratio, so no pulse lasts more than one cycle unless the ratio is 1.
- R5: With the rate-select bit at 1, the auxiliary enable is high in every ready cycle. With it at 0, the auxiliary enable is high in the first ready cycle and in every second cycle after that.
- R6: A strobe seen at clock edge E while the block is stopped or settling is applied at edge E+1. With run set and a settle count S, outputs stay low and ready stays low until edge E+1+S, after which ready is high. S=0 gives ready straight after edge E+1.
- R7: An applied set with the run bit at 0 forces all enables and ready to 0 and keeps them there.
- R8: A strobe taken while running leaves the old ratios unchanged until the 96-cycle frame ends. The new set then starts at the frame start, with all dividers restarted and no settle wait.
- R9: A second strobe during settling replaces the pending set and restarts the settle wait with the new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock; every output is an enable in this domain |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | One-cycle strobe that captures the configuration inputs |
| cfg_codes | input | 20 | Five 4-bit ratio codes; domain d in bits [4d+3:4d] |
| cfg_full_rate | input | 1 | 1: auxiliary enable at full rate; 0: at half rate |
| cfg_run | input | 1 | 1: run the dividers; 0: stop all enables |
| cfg_settle | input | 8 | Cycles to wait before ready when starting from stop |
| dom_tick | output | 5 | One-cycle enable per domain, bit order as the code bus |
| aux_tick | output | 1 | Auxiliary full-rate or half-rate enable |
| clocks_ready | output | 1 | High while the dividers run after the settle wait |

## Verification
A divider counter that is off by one shows as a pulse one cycle early or late. This appears within one ratio period after ready rises, so at most 32 cycles for the slowest code. A frame counter or pending flag in the wrong state shows as a code set applied at the wrong cycle, and every stream then moves out of step from the frame boundary onward. A wrong settle count shifts the rising edge of ready and the first pulse on all five streams by the same number of cycles. The bench compares every output in every cycle of each window, so any of these faults is reported at the first cycle where it appears.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int CODE_W    = 4;
    localparam int RATIO_W   = 6;
    localparam int FRAME_LEN = 96;
    localparam int FRAME_W   = $clog2(FRAME_LEN);

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_ACTIVE = 2'd2
    } phase_e;

    // Non-linear ratio set; unused codes fall back to divide-by-one.
    function automatic logic [RATIO_W-1:0] code_to_ratio(input logic [CODE_W-1:0] code);
        case (code)
            4'd0:    code_to_ratio = RATIO_W'(1);
            4'd1:    code_to_ratio = RATIO_W'(2);
            4'd2:    code_to_ratio = RATIO_W'(3);
            4'd3:    code_to_ratio = RATIO_W'(4);
            4'd4:    code_to_ratio = RATIO_W'(6);
            4'd5:    code_to_ratio = RATIO_W'(8);
            4'd6:    code_to_ratio = RATIO_W'(12);
            4'd7:    code_to_ratio = RATIO_W'(16);
            4'd8:    code_to_ratio = RATIO_W'(24);
            4'd9:    code_to_ratio = RATIO_W'(32);
            default: code_to_ratio = RATIO_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/cdv_domain.sv
module cdv_domain
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
    } dom_s;

    dom_s               dom_d, dom_q;
    logic [RATIO_W-1:0] ratio;

    assign ratio = code_to_ratio(code);

    always_comb begin
        dom_d = dom_q;
        if (restart) begin
            dom_d.cnt = '0;
        end else if (en) begin
            dom_d.cnt = (dom_q.cnt == ratio - RATIO_W'(1)) ? '0 : dom_q.cnt + RATIO_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dom_q <= '0;
        else        dom_q <= dom_d;
    end

    assign tick = en && (dom_q.cnt == '0);

    // R4: a pulse never lasts two cycles when the ratio is above one
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ratio > RATIO_W'(1)) |=> !tick);

    // R2: the running count stays inside the selected ratio
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (dom_q.cnt < ratio));

endmodule

// File: rtl/cdv_sequencer.sv
module cdv_sequencer
    import clkdiv_pkg::*;
#(
    parameter int N_DOM    = 5,
    parameter int SETTLE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_load,
    input  logic [N_DOM*CODE_W-1:0]   cfg_codes,
    input  logic                      cfg_full_rate,
    input  logic                      cfg_run,
    input  logic [SETTLE_W-1:0]       cfg_settle,
    output logic [N_DOM*CODE_W-1:0]   codes_o,
    output logic                      active_o,
    output logic                      restart_o,
    output logic                      aux_o
);

    localparam int                CW         = N_DOM * CODE_W;
    localparam logic [FRAME_W-1:0] FRAME_LAST = FRAME_W'(FRAME_LEN - 1);

    typedef struct packed {
        phase_e              phase;
        logic [SETTLE_W-1:0] wait_cnt;
        logic [FRAME_W-1:0]  frame;
        logic                pend;
        logic [CW-1:0]       sh_codes;
        logic                sh_full;
        logic                sh_run;
        logic [SETTLE_W-1:0] sh_settle;
        logic [CW-1:0]       codes;
        logic                full;
    } seq_s;

    seq_s seq_d, seq_q;
    logic apply;

    assign apply = seq_q.pend && (seq_q.phase != PH_ACTIVE || seq_q.frame == FRAME_LAST);

    always_comb begin
        seq_d = seq_q;
        case (seq_q.phase)
            PH_SETTLE: begin
                if (seq_q.wait_cnt <= SETTLE_W'(1)) begin
                    seq_d.phase = PH_ACTIVE;
                    seq_d.frame = '0;
                end else begin
                    seq_d.wait_cnt = seq_q.wait_cnt - SETTLE_W'(1);
                end
            end
            PH_ACTIVE: begin
                seq_d.frame = (seq_q.frame == FRAME_LAST) ? '0 : seq_q.frame + FRAME_W'(1);
            end
            default: ;
        endcase
        if (apply) begin
            seq_d.pend  = 1'b0;
            seq_d.codes = seq_q.sh_codes;
            seq_d.full  = seq_q.sh_full;
            seq_d.frame = '0;
            if (!seq_q.sh_run) begin
                seq_d.phase = PH_IDLE;
            end else if (seq_q.phase == PH_ACTIVE || seq_q.sh_settle == '0) begin
                seq_d.phase = PH_ACTIVE;
            end else begin
                seq_d.phase    = PH_SETTLE;
                seq_d.wait_cnt = seq_q.sh_settle;
            end
        end
        if (cfg_load) begin
            seq_d.pend      = 1'b1;
            seq_d.sh_codes  = cfg_codes;
            seq_d.sh_full   = cfg_full_rate;
            seq_d.sh_run    = cfg_run;
            seq_d.sh_settle = cfg_settle;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign codes_o   = seq_q.codes;
    assign active_o  = (seq_q.phase == PH_ACTIVE);
    assign restart_o = (seq_d.phase == PH_ACTIVE) && (seq_q.phase != PH_ACTIVE || apply);
    assign aux_o     = active_o && (seq_q.full || !seq_q.frame[0]);

    // R8: codes never change inside a running frame
    a_r8_hold_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_ACTIVE && seq_q.frame != FRAME_LAST) |=> $stable(seq_q.codes));

    // R8: a running frame wraps to its start
    a_r8_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_ACTIVE && seq_q.frame == FRAME_LAST) |=> (seq_q.frame == '0));

    // R5: at half rate the auxiliary enable alternates
    a_r5_aux_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_o && !seq_q.full) |=> !aux_o);

    // R6: the last settle cycle is followed by ready
    a_r6_ready_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_SETTLE && seq_q.wait_cnt == SETTLE_W'(1) && !apply) |=> active_o);

endmodule

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen
    import clkdiv_pkg::*;
#(
    parameter int N_DOM    = 5,
    parameter int SETTLE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_load,
    input  logic [N_DOM*CODE_W-1:0] cfg_codes,
    input  logic                    cfg_full_rate,
    input  logic                    cfg_run,
    input  logic [SETTLE_W-1:0]     cfg_settle,
    output logic [N_DOM-1:0]        dom_tick,
    output logic                    aux_tick,
    output logic                    clocks_ready
);

    logic [N_DOM*CODE_W-1:0] codes;
    logic                    active;
    logic                    restart;

    cdv_sequencer #(.N_DOM(N_DOM), .SETTLE_W(SETTLE_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_load      (cfg_load),
        .cfg_codes     (cfg_codes),
        .cfg_full_rate (cfg_full_rate),
        .cfg_run       (cfg_run),
        .cfg_settle    (cfg_settle),
        .codes_o       (codes),
        .active_o      (active),
        .restart_o     (restart),
        .aux_o         (aux_tick)
    );

    for (genvar gi = 0; gi < N_DOM; gi++) begin : g_dom
        cdv_domain u_dom (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (active),
            .restart (restart),
            .code    (codes[gi*CODE_W +: CODE_W]),
            .tick    (dom_tick[gi])
        );
    end

    assign clocks_ready = active;

    // R1/R7: no enable without ready
    a_r7_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !clocks_ready |-> (dom_tick == '0 && !aux_tick));

endmodule

// File: tb/clk_ratio_gen_bench.sv
module clk_ratio_gen_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        int         cyc;
        logic [4:0] tick;
        logic       aux;
        logic       rdy;
        string      tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [19:0] cfg_codes = '0;
    logic        cfg_full_rate = 1'b0;
    logic        cfg_run = 1'b0;
    logic [7:0]  cfg_settle = '0;
    logic [4:0]  dom_tick;
    logic        aux_tick;
    logic        clocks_ready;

    int          cyc = 0;
    int          n_checks = 0;
    int          n_fails = 0;
    bit          finished = 1'b0;
    exp_item_t   exp_q[$];
    int          ratio_tab[16] = '{1, 2, 3, 4, 6, 8, 12, 16, 24, 32, 1, 1, 1, 1, 1, 1};

    clk_ratio_gen u_clk_ratio_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_load      (cfg_load),
        .cfg_codes     (cfg_codes),
        .cfg_full_rate (cfg_full_rate),
        .cfg_run       (cfg_run),
        .cfg_settle    (cfg_settle),
        .dom_tick      (dom_tick),
        .aux_tick      (aux_tick),
        .clocks_ready  (clocks_ready)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic push_quiet(input int from_c, input int to_c, input string tag);
        for (int c = from_c; c <= to_c; c++) begin
            exp_item_t it;
            it.cyc = c; it.tick = '0; it.aux = 1'b0; it.rdy = 1'b0; it.tag = tag;
            exp_q.push_back(it);
        end
    endtask

    task automatic push_run(input int start, input int j0, input int j1,
                            input logic [19:0] codes, input bit full, input string tag);
        for (int j = j0; j <= j1; j++) begin
            exp_item_t it;
            it.cyc = start + j;
            for (int d = 0; d < 5; d++)
                it.tick[d] = ((j % ratio_tab[codes[d*4 +: 4]]) == 0);
            it.aux = full || ((j % 2) == 0);
            it.rdy = 1'b1;
            it.tag = tag;
            exp_q.push_back(it);
        end
    endtask

    task automatic load_cfg(input logic [19:0] codes, input bit full, input bit run,
                            input logic [7:0] settle);
        cfg_load = 1'b1; cfg_codes = codes; cfg_full_rate = full;
        cfg_run = run; cfg_settle = settle;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // monitor: pops expected items in cycle order and compares
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
                exp_item_t it;
                it = exp_q.pop_front();
                n_checks++;
                if (it.cyc != cyc) begin
                    n_fails++;
                    $display("FAIL %s stale item: cycle %0d expected at %0d", it.tag, cyc, it.cyc);
                end else if (dom_tick !== it.tick || aux_tick !== it.aux || clocks_ready !== it.rdy) begin
                    n_fails++;
                    $display("FAIL %s cycle %0d: tick=%b exp %b aux=%b exp %b ready=%b exp %b",
                             it.tag, cyc, dom_tick, it.tick, aux_tick, it.aux, clocks_ready, it.rdy);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not complete, actual hung, expected done");
        report();
    end

    initial begin
        int c0, a0, a1, a2, a3, ce;
        logic [19:0] codes_a, codes_b, codes_c;
        codes_a = {4'd4, 4'd3, 4'd2, 4'd1, 4'd0};   // R2: ratios 1,2,3,4,6
        codes_b = {4'd9, 4'd8, 4'd7, 4'd6, 4'd5};   // R2: ratios 8,12,16,24,32
        codes_c = {4'd0, 4'd1, 4'd15, 4'd12, 4'd10}; // R3: reserved codes
        @(negedge clk);
        push_quiet(cyc + 1, cyc + 3, "R1");
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 settle from stop, then R2 R4 R5 pattern
        c0 = cyc; a0 = c0 + 2 + 4;
        push_quiet(c0 + 1, a0 - 1, "R6");
        push_run(a0, 0, 20, codes_a, 1'b0, "R2 R4 R5");
        load_cfg(codes_a, 1'b0, 1'b1, 8'd4);

        // R8 reload while running: applied at frame end, no settle
        wait_cyc(a0 + 20);
        a1 = a0 + 96;
        push_run(a0, 21, 95, codes_a, 1'b0, "R8 old set");
        push_run(a1, 0, 95, codes_b, 1'b1, "R2 R5 R8");
        load_cfg(codes_b, 1'b1, 1'b1, 8'd7);

        // R3 reserved codes
        wait_cyc(a1 + 30);
        a2 = a1 + 96;
        push_run(a2, 0, 95, codes_c, 1'b0, "R3 R8");
        load_cfg(codes_c, 1'b0, 1'b1, 8'd3);

        // R7 stop at the frame end
        wait_cyc(a2 + 10);
        push_quiet(a2 + 96, a2 + 110, "R7");
        load_cfg(20'h0, 1'b0, 1'b0, 8'd5);

        // R9 second strobe during settle restarts the wait
        wait_cyc(a2 + 112);
        ce = cyc; a3 = ce + 7;
        push_quiet(ce + 1, a3 - 1, "R9 R6");
        push_run(a3, 0, 40, 20'h33333, 1'b1, "R9");
        load_cfg(20'h11111, 1'b0, 1'b1, 8'd10);
        wait_cyc(ce + 3);
        load_cfg(20'h33333, 1'b1, 1'b1, 8'd2);

        wait_cyc(a3 + 42);
        while (exp_q.size() > 0) @(negedge clk);
        report();
    end

endmodule